// File: doc/BRIEF.md
# DDR Write Burst Data Path

This block converts a write request into a double-data-rate write burst at the pins of a DDR SDRAM controller. A request carries up to eight data words, one mask bit per byte lane per word, and a burst length code. The block emits one data beat per fast-clock cycle on `dq`, a data strobe per byte lane with its own output enable, and one mask bit per byte lane that tells the memory to skip that byte for that beat.

The model is cycle-level and runs on a single fast clock `clk2x` whose frequency is twice the command clock. Every second fast edge is a command edge, flagged by `cmd_phase`; requests are sampled only there. Data beats change on the falling edge of `clk2x` and the strobe changes on the rising edge. The strobe therefore sits a quarter of a command period away from the data and each strobe edge falls in the middle of its beat. The strobe is driven low for a preamble before the first edge, toggles once per beat and is released after a half-clock postamble. A new burst may follow the previous one without a gap, in which case the strobe keeps toggling. The flag `wr_to_rd_ok` indicates when the write-to-read turnaround has elapsed.

Top module: `ddr_wr_burst`

## Requirements
- R1: After reset and while no burst is in flight, `dq_oe` and every `dqs_oe` bit are low, `dq`, `dqs` and `dm` are all zero, and `wr_to_rd_ok` is high.
- R2: `cmd_phase` is high in the first fast cycle after reset and alternates on every fast edge after that; `wr_valid` is sampled only on rising edges of `clk2x` at which `cmd_phase` is high, and a request presented at any other edge is ignored.
- R3: `wr_bl` selects the burst length: 2'b00 gives 2 beats, 2'b01 gives 4 beats and 2'b10 gives 8 beats; code 2'b11 is reserved and the request is ignored. `dq_oe` is high for exactly that many consecutive fast cycles.
- R4: For a request accepted at fast edge c, beat b (`wr_data[b*DQ_W +: DQ_W]`) is driven on `dq` from the falling edge after fast edge c+1+b until the next falling edge. `dq` reads zero outside bursts.
- R5: `dm[l]` carries `wr_mask[b*LANES + l]` during beat b (high means the byte is not written) and is low whenever `dq_oe` is low.
- R6: Starting a burst from idle, `dqs_oe` rises at fast edge c+1 while `dqs` stays low, which gives a preamble of half a command clock.
- R7: `dqs` rises at fast edge c+2, which is one command clock after the request. After that it changes on every rising edge of `clk2x` and is high for even beats and low for odd beats, so each strobe edge sits in the middle of its beat.
- R8: After the last beat's falling strobe edge, `dqs` stays low for one fast cycle (half a command clock) and then `dqs_oe` drops.
- R9: All byte lanes carry the same strobe and strobe enable. Lane l carries data bits 8l+7..8l and its own mask bit.
- R10: A request is accepted only at a fast edge at or after c+BL, where c and BL are the edge and length of the last accepted burst. An earlier request is ignored.
- R11: A request accepted exactly at c+BL follows the previous burst without a gap: `dq_oe` and `dqs_oe` stay high, no new preamble appears and `dqs` keeps alternating.
- R12: `wr_to_rd_ok` drops at the edge that accepts a request. With no later request it rises again at fast edge c+BL+2+2*WTR_CYC, which is WTR_CYC command clocks after the last data pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Fast clock at twice the command rate |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write request present |
| wr_bl | input | 2 | Burst length code (00:2, 01:4, 10:8, 11 reserved) |
| wr_data | input | MAX_BL*DQ_W | Burst words, beat 0 in the low bits |
| wr_mask | input | MAX_BL*DQ_W/8 | Per-beat per-lane write mask, beat 0 in the low bits |
| cmd_phase | output | 1 | High in fast cycles that end at a command edge |
| dq | output | DQ_W | Data beat |
| dq_oe | output | 1 | Data output enable |
| dqs | output | DQ_W/8 | Data strobe, one per byte lane |
| dqs_oe | output | DQ_W/8 | Strobe output enable, one per byte lane |
| dm | output | DQ_W/8 | Write mask, one per byte lane |
| wr_to_rd_ok | output | 1 | Write-to-read turnaround has elapsed |

## Verification
The bench builds the block with DQ_W=16, MAX_BL=8 and WTR_CYC=1. Two lanes let it compare the strobes lane against lane and check that each mask bit follows its own byte. The eight-beat ceiling makes all three legal length codes and the reserved one reachable. A one-clock turnaround keeps the flag's rise close enough to the end of a burst that back-to-back and gap-of-one sequences both exercise it. Random requests arrive on command and non-command edges, during and after bursts, so that acceptance, rejection and seamless chaining all occur many times.

// File: rtl/ddrw_pkg.sv
// Shared definitions for the DDR write burst data path.
// Assumes burst lengths are powers of two selected by a two-bit code.
package ddrw_pkg;
    typedef logic [1:0] bl_code_t;

    localparam bl_code_t BL_CODE_2    = 2'b00;
    localparam bl_code_t BL_CODE_4    = 2'b01;
    localparam bl_code_t BL_CODE_8    = 2'b10;
    localparam bl_code_t BL_CODE_RSVD = 2'b11;

    // Number of beats a length code asks for (reserved code yields 16).
    function automatic int beats_of(input bl_code_t code);
        return 2 << code;
    endfunction
endpackage

// File: rtl/ddrw_cadence.sv
// Command cadence generator: marks every second fast edge as a command edge.
// Assumes the fast clock runs at exactly twice the command clock.
module ddrw_cadence (
    input  logic clk2x,
    input  logic rst_n,
    output logic cmd_phase
);
    logic odd_q;

    // Toggle the half-cycle marker on every fast edge.
    always_ff @(posedge clk2x) begin
        if (!rst_n) odd_q <= 1'b0;
        else        odd_q <= ~odd_q;
    end

    assign cmd_phase = ~odd_q;
endmodule

// File: rtl/ddrw_slot_queue.sv
// Beat slot delay line. Position 0 holds the beat presented in the current
// fast cycle and position i the beat i cycles ahead. An accepted request
// loads its beats into positions 1..BL. Acceptance needs a command edge, a
// legal length and free positions 2 and above. Assumes MAX_BL >= 2.
module ddrw_slot_queue
    import ddrw_pkg::*;
#(
    parameter int DQ_W   = 16,
    parameter int LANES  = 2,
    parameter int MAX_BL = 8
) (
    input  logic                    clk2x,
    input  logic                    rst_n,
    input  logic                    cmd_phase,
    input  logic                    wr_valid,
    input  bl_code_t                wr_bl,
    input  logic [MAX_BL*DQ_W-1:0]  wr_data,
    input  logic [MAX_BL*LANES-1:0] wr_mask,
    output logic                    head_vld,
    output logic                    head_rise,
    output logic [DQ_W-1:0]         head_data,
    output logic [LANES-1:0]        head_mask,
    output logic                    next_vld,
    output logic                    any_next
);
    localparam int DEPTH = MAX_BL + 1;

    logic             vld_q  [DEPTH];
    logic             vld_d  [DEPTH];
    logic             rise_q [DEPTH];
    logic             rise_d [DEPTH];
    logic [DQ_W-1:0]  dat_q  [DEPTH];
    logic [DQ_W-1:0]  dat_d  [DEPTH];
    logic [LANES-1:0] msk_q  [DEPTH];
    logic [LANES-1:0] msk_d  [DEPTH];

    int   nbeats;
    logic bl_ok;
    logic slots_free;
    logic accept;

    // Decode the requested length and decide whether it is accepted.
    always_comb begin
        nbeats     = beats_of(wr_bl);
        bl_ok      = (wr_bl != BL_CODE_RSVD) && (nbeats <= MAX_BL);
        slots_free = 1'b1;
        for (int k = 2; k < DEPTH; k++) begin
            if (vld_q[k]) slots_free = 1'b0;
        end
        accept = cmd_phase && wr_valid && bl_ok && slots_free;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_pos
        logic             sh_v;
        logic             sh_r;
        logic [DQ_W-1:0]  sh_d;
        logic [LANES-1:0] sh_m;

        if (i == DEPTH - 1) begin : g_tail
            // The far end shifts in an empty slot.
            always_comb begin
                sh_v = 1'b0;
                sh_r = 1'b0;
                sh_d = '0;
                sh_m = '0;
            end
        end else begin : g_body
            // Each slot moves one position toward the head per fast cycle.
            always_comb begin
                sh_v = vld_q[i+1];
                sh_r = rise_q[i+1];
                sh_d = dat_q[i+1];
                sh_m = msk_q[i+1];
            end
        end

        if (i == 0) begin : g_head
            // The head slot is only ever fed by the shift.
            always_comb begin
                vld_d[i]  = sh_v;
                rise_d[i] = sh_r;
                dat_d[i]  = sh_d;
                msk_d[i]  = sh_m;
            end
        end else begin : g_load
            localparam int B = i - 1;
            // Slot i takes beat i-1 of an accepted burst, otherwise the shift.
            always_comb begin
                if (accept && (B < nbeats)) begin
                    vld_d[i]  = 1'b1;
                    rise_d[i] = ((B % 2) == 0);
                    dat_d[i]  = wr_data[B*DQ_W +: DQ_W];
                    msk_d[i]  = wr_mask[B*LANES +: LANES];
                end else begin
                    vld_d[i]  = sh_v;
                    rise_d[i] = sh_r;
                    dat_d[i]  = sh_d;
                    msk_d[i]  = sh_m;
                end
            end
        end
    end

    // Register the slot line.
    always_ff @(posedge clk2x) begin
        for (int k = 0; k < DEPTH; k++) begin
            if (!rst_n) begin
                vld_q[k]  <= 1'b0;
                rise_q[k] <= 1'b0;
                dat_q[k]  <= '0;
                msk_q[k]  <= '0;
            end else begin
                vld_q[k]  <= vld_d[k];
                rise_q[k] <= rise_d[k];
                dat_q[k]  <= dat_d[k];
                msk_q[k]  <= msk_d[k];
            end
        end
    end

    // Flag whether any beat remains in flight after this edge.
    always_comb begin
        any_next = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            if (vld_d[k]) any_next = 1'b1;
        end
    end

    assign head_vld  = vld_q[0];
    assign head_rise = rise_q[0];
    assign head_data = dat_q[0];
    assign head_mask = msk_q[0];
    assign next_vld  = vld_q[1];
endmodule

// File: rtl/ddrw_strobe_gen.sv
// Strobe generator, clocked on the rising fast edge. It drives the strobe low
// one cycle before the first beat (preamble), gives each beat its level, and
// releases after the postamble that follows the last beat. Assumes even
// burst lengths, so a burst always ends on a low level.
module ddrw_strobe_gen #(
    parameter int LANES = 2
) (
    input  logic             clk2x,
    input  logic             rst_n,
    input  logic             head_vld,
    input  logic             head_rise,
    input  logic             next_vld,
    output logic [LANES-1:0] dqs,
    output logic [LANES-1:0] dqs_oe
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // One strobe and enable per byte lane, all driven from the same slot.
        always_ff @(posedge clk2x) begin
            if (!rst_n) begin
                dqs[l]    <= 1'b0;
                dqs_oe[l] <= 1'b0;
            end else begin
                dqs[l]    <= head_vld && head_rise;
                dqs_oe[l] <= head_vld || next_vld;
            end
        end
    end
endmodule

// File: rtl/ddrw_beat_drive.sv
// Data and mask drivers, clocked on the falling fast edge so the data sits a
// quarter command period away from the strobe. Drives zero when idle.
module ddrw_beat_drive #(
    parameter int DQ_W  = 16,
    parameter int LANES = 2
) (
    input  logic             clk2x,
    input  logic             rst_n,
    input  logic             head_vld,
    input  logic [DQ_W-1:0]  head_data,
    input  logic [LANES-1:0] head_mask,
    output logic [DQ_W-1:0]  dq,
    output logic             dq_oe,
    output logic [LANES-1:0] dm
);
    // Present the head slot for one fast cycle, or quiet outputs when empty.
    always_ff @(negedge clk2x) begin
        if (!rst_n) begin
            dq    <= '0;
            dq_oe <= 1'b0;
            dm    <= '0;
        end else begin
            dq_oe <= head_vld;
            dq    <= head_vld ? head_data : '0;
            dm    <= head_vld ? head_mask : '0;
        end
    end
endmodule

// File: rtl/ddrw_turnaround.sv
// Write-to-read turnaround timer. It counts fast cycles since the last beat
// left the slot line and raises the flag once the required command clocks
// past the last data pair have elapsed.
module ddrw_turnaround #(
    parameter int WTR_CYC = 1
) (
    input  logic clk2x,
    input  logic rst_n,
    input  logic any_next,
    output logic wr_to_rd_ok
);
    localparam int LIM = 2 * WTR_CYC + 2;
    localparam int CW  = $clog2(LIM + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    // Saturating count of empty fast cycles.
    always_comb begin
        if (any_next)                cnt_d = '0;
        else if (cnt_q != CW'(LIM))  cnt_d = cnt_q + 1'b1;
        else                         cnt_d = cnt_q;
    end

    // Hold the count and the flag that it has reached its limit.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            cnt_q       <= CW'(LIM);
            wr_to_rd_ok <= 1'b1;
        end else begin
            cnt_q       <= cnt_d;
            wr_to_rd_ok <= !any_next && (cnt_d == CW'(LIM));
        end
    end
endmodule

// File: rtl/ddr_wr_burst.sv
// DDR write burst data path top. It joins the command cadence, the beat slot
// line, the strobe generator, the data drivers and the turnaround timer.
// Assumes DQ_W is a multiple of 8 and MAX_BL is 2, 4 or 8.
module ddr_wr_burst
    import ddrw_pkg::*;
#(
    parameter int DQ_W    = 16,
    parameter int MAX_BL  = 8,
    parameter int WTR_CYC = 1
) (
    input  logic                         clk2x,
    input  logic                         rst_n,
    input  logic                         wr_valid,
    input  logic [1:0]                   wr_bl,
    input  logic [MAX_BL*DQ_W-1:0]       wr_data,
    input  logic [MAX_BL*(DQ_W/8)-1:0]   wr_mask,
    output logic                         cmd_phase,
    output logic [DQ_W-1:0]              dq,
    output logic                         dq_oe,
    output logic [DQ_W/8-1:0]            dqs,
    output logic [DQ_W/8-1:0]            dqs_oe,
    output logic [DQ_W/8-1:0]            dm,
    output logic                         wr_to_rd_ok
);
    localparam int LANES = DQ_W / 8;

    logic             head_vld;
    logic             head_rise;
    logic [DQ_W-1:0]  head_data;
    logic [LANES-1:0] head_mask;
    logic             next_vld;
    logic             any_next;

    ddrw_cadence u_cadence (
        .clk2x     (clk2x),
        .rst_n     (rst_n),
        .cmd_phase (cmd_phase)
    );

    ddrw_slot_queue #(.DQ_W(DQ_W), .LANES(LANES), .MAX_BL(MAX_BL)) u_queue (
        .clk2x     (clk2x),
        .rst_n     (rst_n),
        .cmd_phase (cmd_phase),
        .wr_valid  (wr_valid),
        .wr_bl     (bl_code_t'(wr_bl)),
        .wr_data   (wr_data),
        .wr_mask   (wr_mask),
        .head_vld  (head_vld),
        .head_rise (head_rise),
        .head_data (head_data),
        .head_mask (head_mask),
        .next_vld  (next_vld),
        .any_next  (any_next)
    );

    ddrw_strobe_gen #(.LANES(LANES)) u_strobe (
        .clk2x     (clk2x),
        .rst_n     (rst_n),
        .head_vld  (head_vld),
        .head_rise (head_rise),
        .next_vld  (next_vld),
        .dqs       (dqs),
        .dqs_oe    (dqs_oe)
    );

    ddrw_beat_drive #(.DQ_W(DQ_W), .LANES(LANES)) u_beats (
        .clk2x     (clk2x),
        .rst_n     (rst_n),
        .head_vld  (head_vld),
        .head_data (head_data),
        .head_mask (head_mask),
        .dq        (dq),
        .dq_oe     (dq_oe),
        .dm        (dm)
    );

    ddrw_turnaround #(.WTR_CYC(WTR_CYC)) u_wtr (
        .clk2x       (clk2x),
        .rst_n       (rst_n),
        .any_next    (any_next),
        .wr_to_rd_ok (wr_to_rd_ok)
    );
endmodule

// File: rtl/ddr_wr_burst_chk.sv
// Protocol checker for the DDR write burst data path, bound to the top.
module ddr_wr_burst_chk #(
    parameter int DQ_W    = 16,
    parameter int MAX_BL  = 8,
    parameter int WTR_CYC = 1
) (
    input logic                       clk2x,
    input logic                       rst_n,
    input logic                       cmd_phase,
    input logic                       dq_oe,
    input logic [DQ_W/8-1:0]          dqs,
    input logic [DQ_W/8-1:0]          dqs_oe,
    input logic [DQ_W/8-1:0]          dm,
    input logic                       wr_to_rd_ok
);
    localparam int LANES = DQ_W / 8;

    // R9
    lanes_match_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        (dqs_oe == {LANES{dqs_oe[0]}}) && (dqs == {LANES{dqs[0]}}));

    // R1
    idle_strobe_low_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        !dqs_oe[0] |-> !dqs[0]);

    // R6
    preamble_low_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        $rose(dqs_oe[0]) |-> !dqs[0]);

    // R7
    strobe_toggle_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        (dqs_oe[0] && dqs[0]) |=> !dqs[0]);

    // R8
    postamble_low_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        $fell(dqs_oe[0]) |-> !$past(dqs[0]));

    // R5
    mask_quiet_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        !dq_oe |-> (dm == '0));

    // R12
    turnaround_quiet_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        wr_to_rd_ok |-> (!dq_oe && !dqs_oe[0]));

    // R2
    cadence_alt_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        $past(rst_n) |-> (cmd_phase != $past(cmd_phase)));
endmodule

bind ddr_wr_burst ddr_wr_burst_chk #(
    .DQ_W(DQ_W), .MAX_BL(MAX_BL), .WTR_CYC(WTR_CYC)
) u_chk (
    .clk2x       (clk2x),
    .rst_n       (rst_n),
    .cmd_phase   (cmd_phase),
    .dq_oe       (dq_oe),
    .dqs         (dqs),
    .dqs_oe      (dqs_oe),
    .dm          (dm),
    .wr_to_rd_ok (wr_to_rd_ok)
);

// File: tb/ddr_wr_burst_tb.sv
// Bench for the DDR write burst data path: directed corners plus seeded
// random requests, checked against a schedule model kept per fast edge.
module ddr_wr_burst_tb;
    localparam int DQ_W   = 16;
    localparam int MAX_BL = 8;
    localparam int WTR    = 1;
    localparam int LANES  = DQ_W / 8;
    localparam int NSLOT  = 8192;

    logic                       clk2x = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       wr_valid = 1'b0;
    logic [1:0]                 wr_bl = 2'b00;
    logic [MAX_BL*DQ_W-1:0]     wr_data = '0;
    logic [MAX_BL*LANES-1:0]    wr_mask = '0;
    logic                       cmd_phase;
    logic [DQ_W-1:0]            dq;
    logic                       dq_oe;
    logic [LANES-1:0]           dqs;
    logic [LANES-1:0]           dqs_oe;
    logic [LANES-1:0]           dm;
    logic                       wr_to_rd_ok;

    ddr_wr_burst u_dut (
        .clk2x(clk2x), .rst_n(rst_n), .wr_valid(wr_valid), .wr_bl(wr_bl),
        .wr_data(wr_data), .wr_mask(wr_mask), .cmd_phase(cmd_phase),
        .dq(dq), .dq_oe(dq_oe), .dqs(dqs), .dqs_oe(dqs_oe), .dm(dm),
        .wr_to_rd_ok(wr_to_rd_ok)
    );

    always #5 clk2x = ~clk2x;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    string scen   = "R1";

    // Expected schedule: beat presented in the fast cycle after edge e.
    bit               hv [NSLOT];
    bit               hr [NSLOT];
    logic [DQ_W-1:0]  hd [NSLOT];
    logic [LANES-1:0] hm [NSLOT];

    int E      = -1;
    int last_c = 0;
    int last_b = 0;
    bit any_acc = 1'b0;

    function automatic bit v_at(input int e);
        return (e >= 0) ? hv[e % NSLOT] : 1'b0;
    endfunction

    function automatic bit r_at(input int e);
        return (e >= 0) ? hr[e % NSLOT] : 1'b0;
    endfunction

    function automatic int bl_beats(input logic [1:0] c);
        return 2 << c;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) edge=%0d act=%0h exp=%0h", tag, scen, E, act, exp);
        end
    endtask

    // Advance one fast edge: update the model, check strobe, then data.
    task automatic step();
        bit eo, ed, ok;
        @(posedge clk2x);
        E++;
        if (wr_valid && (E % 2 == 0) && (wr_bl != 2'b11) && (!any_acc || E >= last_c + last_b)) begin
            for (int b = 0; b < bl_beats(wr_bl); b++) begin
                hv[(E+1+b) % NSLOT] = 1'b1;
                hr[(E+1+b) % NSLOT] = (b % 2 == 0);
                hd[(E+1+b) % NSLOT] = wr_data[b*DQ_W +: DQ_W];
                hm[(E+1+b) % NSLOT] = wr_mask[b*LANES +: LANES];
            end
            last_c  = E;
            last_b  = bl_beats(wr_bl);
            any_acc = 1'b1;
        end
        hv[(E+12) % NSLOT] = 1'b0;
        #2;
        eo = v_at(E-1) || v_at(E);
        ed = v_at(E-1) && r_at(E-1);
        ok = !any_acc || (E >= last_c + last_b + 2 + 2*WTR);
        for (int l = 0; l < LANES; l++) begin
            chk("R6 R8 R9 dqs_oe", 64'(dqs_oe[l]), 64'(eo));
            chk("R7 R9 dqs", 64'(dqs[l]), 64'(ed));
        end
        chk("R2 cmd_phase", 64'(cmd_phase), 64'((E+1) % 2 == 0));
        chk("R12 wr_to_rd_ok", 64'(wr_to_rd_ok), 64'(ok));
        @(negedge clk2x);
        #1;
        chk("R3 dq_oe", 64'(dq_oe), 64'(v_at(E)));
        chk("R4 dq", 64'(dq), v_at(E) ? 64'(hd[E % NSLOT]) : 64'd0);
        chk("R5 dm", 64'(dm), v_at(E) ? 64'(hm[E % NSLOT]) : 64'd0);
        wr_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic fill_random();
        for (int b = 0; b < MAX_BL; b++) wr_data[b*DQ_W +: DQ_W] = DQ_W'($urandom);
        wr_mask = (MAX_BL*LANES)'($urandom);
    endtask

    // Present a request at the next command edge.
    task automatic issue(input logic [1:0] code);
        if ((E + 1) % 2 != 0) step();
        fill_random();
        wr_bl    = code;
        wr_valid = 1'b1;
        step();
    endtask

    initial begin
        void'($urandom(32'h5eed_d0d0));
        for (int i = 0; i < NSLOT; i++) begin
            hv[i] = 1'b0; hr[i] = 1'b0; hd[i] = '0; hm[i] = '0;
        end
        repeat (4) @(posedge clk2x);
        @(negedge clk2x);
        #1;
        scen = "R1";
        chk("R1 dq_oe", 64'(dq_oe), 64'd0);
        chk("R1 dqs_oe", 64'(dqs_oe), 64'd0);
        chk("R1 dm", 64'(dm), 64'd0);
        chk("R1 dq", 64'(dq), 64'd0);
        chk("R1 wr_to_rd_ok", 64'(wr_to_rd_ok), 64'd1);
        chk("R2 cmd_phase after reset", 64'(cmd_phase), 64'd1);
        rst_n = 1'b1;
        idle(4);

        scen = "R3 lengths";
        issue(2'b00); idle(12);
        issue(2'b01); idle(12);
        issue(2'b10); idle(14);

        scen = "R3 reserved";
        issue(2'b11); idle(10);

        scen = "R2 off-phase";
        if ((E + 1) % 2 == 0) step();
        fill_random(); wr_bl = 2'b01; wr_valid = 1'b1; step();
        idle(10);

        scen = "R11 back-to-back";
        issue(2'b01); idle(2);
        issue(2'b00);
        issue(2'b10); idle(6);
        issue(2'b01); idle(12);

        scen = "R10 busy";
        issue(2'b10); idle(2);
        issue(2'b00); idle(1);
        issue(2'b01); idle(12);

        scen = "R5 full mask";
        if ((E + 1) % 2 != 0) step();
        fill_random(); wr_mask = '1; wr_bl = 2'b10; wr_valid = 1'b1; step();
        idle(12);

        scen = "random";
        for (int i = 0; i < 1500; i++) begin
            if ($urandom_range(9) < 4) begin
                fill_random();
                wr_bl    = 2'($urandom);
                wr_valid = 1'b1;
            end
            step();
        end
        idle(20);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired at edge %0d", E);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule